// File: doc/BRIEF.md
# Packet Page Pool MMU

This block hands out and takes back the fixed-size packet pages of a small Ethernet controller's buffer memory. A bitmap records which pages are in use. Three ordered queues of page numbers sit beside it: frames waiting to be sent, frames already sent and waiting for software, and frames received and waiting for software. Software drives it through a 3-bit command taken from the top of a command byte, a current packet number, an interrupt acknowledge byte and an interrupt mask byte. The transmit engine removes pages from the send queue with a strobe. The receive side asks for a page with a strobe.

The block reports the last allocation result, the heads of the queues and the number of pages in use. It keeps an interrupt status byte. Some status bits are set by events and some are forced on by how full the queues are. A single interrupt line is driven from the status byte and the mask. A transmit allocation that finds no free page stays pending, and it is granted by itself on the next page release.

Top module: `page_pool_mmu`

## Requirements
- R1: `cmd_code` (bits 7:5 of the command byte) selects: 0 no-op, 1 allocate for transmit, 2 reset all (bitmap, all three queues, result to 0, pending cleared), 3 pop receive queue, 4 pop receive queue and free its head page, 5 free page `pkt_num`, 6 enqueue `pkt_num` for transmit, 7 empty the send and sent queues.
- R2: An allocation always takes the lowest-numbered free page and marks it used. The result byte is the page number with bit 7 clear. When every page is in use, the result byte is 0x80.
- R3: Command 1 first loads 0x80 into the result and clears status bit 3 (allocation done). On success it loads the page and sets bit 3. On failure the request stays pending. Any later page release then grants the lowest free page in that same cycle, loads the result and sets bit 3.
- R4: `done_head` and `rx_head` read 0x80 when their queue is empty. Otherwise they read the head page number, zero-extended.
- R5: A receive pop removes the head and moves the other entries forward. Bit 0 (receive) is set if entries remain and cleared if the queue ends up empty. A pop of an empty queue changes no queue and clears bit 0.
- R6: Status bit 2 (send queue idle) is forced to 1 whenever the send queue is empty. Status bit 1 (sent) is forced to 1 whenever the sent queue is not empty. Both bits otherwise hold until acknowledged.
- R7: An acknowledge write clears the status bits selected by `ack_byte & 0xD6`. If `ack_byte` bit 1 is set, one entry is popped from the sent queue.
- R8: `irq` is 1 exactly when `int_status & int_mask` is non-zero. After reset the status is 0x04 and the mask is 0. A mask write loads `mask_byte`.
- R9: `tx_take` with a non-empty send queue removes its head. The page is freed when `auto_rel` is 1, and otherwise appended to the sent queue, where it is dropped if that queue is full. An enqueue into a full send queue is ignored.
- R10: `used_pages` is the number of set bits in the allocation bitmap.
- R11: `rx_req` is accepted (`rx_accept` high, in the same cycle) only if a page is free and the receive queue is not full. It then takes the lowest free page, appends it to the receive queue and sets status bit 0.
- R12: At most one event is applied per cycle, in this priority: command, then acknowledge, then `tx_take`, then `rx_req`. A mask write is applied alongside any of them. Results are visible after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 3 | Command code (bits 7:5 of the command byte) |
| pkt_num | input | PW | Current packet number for commands 5 and 6 |
| auto_rel | input | 1 | Free pages on transmit instead of queueing them as sent |
| ack_wr | input | 1 | Interrupt acknowledge strobe |
| ack_byte | input | 8 | Acknowledge value |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_byte | input | 8 | New interrupt mask |
| tx_take | input | 1 | Transmit engine consumes the send queue head |
| rx_req | input | 1 | Receive side requests a page |
| rx_accept | output | 1 | Receive request granted this cycle |
| alloc_result | output | 8 | Last transmit allocation result |
| tx_pending | output | 1 | Send queue not empty |
| tx_head | output | PW | Send queue head page |
| done_head | output | 8 | Sent queue head, 0x80 if empty |
| rx_head | output | 8 | Receive queue head, 0x80 if empty |
| used_pages | output | CW | Count of allocated pages |
| int_status | output | 8 | Interrupt status byte |
| irq | output | 1 | Masked interrupt request |

## Verification
Every registered result is due one rising edge after the cycle in which its stimulus is held: the result byte, queue heads, page count, status byte and interrupt line. The bench therefore drives inputs just after a falling edge, advances its behavioural model at the rising edge, and compares all registered outputs at the following falling edge. `rx_accept` is combinational and is due in the stimulus cycle itself. It is compared 1 ns after the inputs settle and before the edge that commits the grant.

// File: rtl/ppm_pkg.sv
`timescale 1ns/1ps
package ppm_pkg;
   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_ALLOC   = 3'd1,
      OP_RESET   = 3'd2,
      OP_RX_POP  = 3'd3,
      OP_RX_FREE = 3'd4,
      OP_REL     = 3'd5,
      OP_TX_PUSH = 3'd6,
      OP_TX_CLR  = 3'd7
   } ppm_op_e;

   localparam int IB_RX     = 0;
   localparam int IB_TXDONE = 1;
   localparam int IB_TXIDLE = 2;
   localparam int IB_ALLOC  = 3;

   localparam logic [7:0] ACK_CLR_MASK = 8'hD6;
   localparam logic [7:0] NO_PAGE      = 8'h80;
   localparam logic [7:0] STATUS_RST   = 8'h04;

   localparam int QI_TX   = 0;
   localparam int QI_DONE = 1;
   localparam int QI_RX   = 2;
   localparam int NUM_Q   = 3;
endpackage

// File: rtl/ppm_page_map.sv
`timescale 1ns/1ps
module ppm_page_map #(
   parameter int NUM_PAGES = 4,
   localparam int PW = $clog2(NUM_PAGES),
   localparam int CW = $clog2(NUM_PAGES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_all,
   input  logic          rel_en,
   input  logic [PW-1:0] rel_idx,
   input  logic          alloc_en,
   output logic [PW-1:0] grant_idx,
   output logic          any_free,
   output logic [CW-1:0] used_cnt
);
   logic [NUM_PAGES-1:0] map_q;
   logic [NUM_PAGES-1:0] map_rel;

   // bitmap as seen after this cycle's release
   always_comb begin
      map_rel = map_q;
      for (int i = 0; i < NUM_PAGES; i++) begin
         if (rel_en && (rel_idx == PW'(i))) map_rel[i] = 1'b0;
      end
   end

   // lowest-numbered free page wins
   always_comb begin
      grant_idx = '0;
      for (int i = NUM_PAGES - 1; i >= 0; i--) begin
         if (!map_rel[i]) grant_idx = PW'(i);
      end
   end

   assign any_free = !(&map_rel);

   always_comb begin
      used_cnt = '0;
      for (int i = 0; i < NUM_PAGES; i++) used_cnt = used_cnt + CW'(map_q[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q <= '0;
      end else if (clr_all) begin
         map_q <= '0;
      end else begin
         map_q <= map_rel;
         if (alloc_en) map_q[grant_idx] <= 1'b1;
      end
   end

   AST_GRANT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && !clr_all) |=> map_q[$past(grant_idx)]); // R2
   AST_CLEAR_EMPTIES_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (used_cnt == '0)); // R1
endmodule

// File: rtl/ppm_queue.sv
`timescale 1ns/1ps
module ppm_queue #(
   parameter int DEPTH = 4,
   parameter int DW    = 2,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] cnt_nxt,
   output logic          empty,
   output logic          full
);
   logic [DW-1:0] ent_q     [DEPTH];
   logic [DW-1:0] shift_src [DEPTH];
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] wr_pos;
   logic          pop_ok;
   logic          push_ok;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CW'(DEPTH));
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);
   assign wr_pos  = cnt_q - CW'(pop_ok);
   assign cnt_nxt = clr ? '0 : (cnt_q + CW'(push_ok) - CW'(pop_ok));
   assign head    = ent_q[0];
   assign cnt     = cnt_q;

   // each slot refills from its successor; the tail slot keeps its value
   for (genvar i = 0; i < DEPTH; i++) begin : g_src
      if (i == DEPTH - 1) begin : g_tail
         assign shift_src[i] = ent_q[i];
      end else begin : g_body
         assign shift_src[i] = ent_q[i+1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      end else begin
         cnt_q <= cnt_nxt;
         for (int i = 0; i < DEPTH; i++) begin
            if (push_ok && (wr_pos == CW'(i))) ent_q[i] <= din;
            else if (pop_ok)                   ent_q[i] <= shift_src[i];
         end
      end
   end

   AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> (cnt_q == $past(cnt_q))); // R9
   AST_EMPTY_POP_HARMLESS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !clr) |=> empty); // R5
endmodule

// File: rtl/ppm_irq.sv
`timescale 1ns/1ps
module ppm_irq import ppm_pkg::*; #(
   parameter int SW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] set_bits,
   input  logic [SW-1:0] clr_bits,
   input  logic [SW-1:0] force_bits,
   input  logic          mask_wr,
   input  logic [SW-1:0] mask_din,
   output logic [SW-1:0] status,
   output logic          irq
);
   logic [SW-1:0] status_q;
   logic [SW-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= SW'(STATUS_RST);
         mask_q   <= '0;
      end else begin
         status_q <= ((status_q & ~clr_bits) | set_bits) | force_bits;
         if (mask_wr) mask_q <= mask_din;
      end
   end

   assign status = status_q;
   assign irq    = |(status_q & mask_q);

   AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr && (mask_din == '0)) |=> !irq); // R8
endmodule

// File: rtl/page_pool_mmu.sv
`timescale 1ns/1ps
module page_pool_mmu import ppm_pkg::*; #(
   parameter int NUM_PAGES = 4,
   localparam int PW = $clog2(NUM_PAGES),
   localparam int CW = $clog2(NUM_PAGES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_wr,
   input  logic [2:0]    cmd_code,
   input  logic [PW-1:0] pkt_num,
   input  logic          auto_rel,
   input  logic          ack_wr,
   input  logic [7:0]    ack_byte,
   input  logic          mask_wr,
   input  logic [7:0]    mask_byte,
   input  logic          tx_take,
   input  logic          rx_req,
   output logic          rx_accept,
   output logic [7:0]    alloc_result,
   output logic          tx_pending,
   output logic [PW-1:0] tx_head,
   output logic [7:0]    done_head,
   output logic [7:0]    rx_head,
   output logic [CW-1:0] used_pages,
   output logic [7:0]    int_status,
   output logic          irq
);
   initial begin
      if (NUM_PAGES < 2 || NUM_PAGES > 64)
         $fatal(1, "page_pool_mmu: NUM_PAGES must lie in 2..64");
   end

   ppm_op_e op;
   logic do_alloc, do_reset, do_rx_pop, do_rx_free, do_rel, do_txpush, do_txclr;
   logic rx_pop_any, ev_ack, ev_tx, rx_window;
   logic rel_en, retry_ok, alloc_ok, alloc_en, any_free;
   logic [PW-1:0] rel_idx, grant_idx;
   logic [7:0] res_q;
   logic       pend_q;
   logic [7:0] set_bits, clr_bits, force_bits;

   logic          q_clr     [NUM_Q];
   logic          q_push    [NUM_Q];
   logic          q_pop     [NUM_Q];
   logic [PW-1:0] q_din     [NUM_Q];
   logic [PW-1:0] q_head    [NUM_Q];
   logic [CW-1:0] q_cnt     [NUM_Q];
   logic [CW-1:0] q_cnt_nxt [NUM_Q];
   logic          q_empty   [NUM_Q];
   logic          q_full    [NUM_Q];

   // ---------------- event selection ----------------
   assign op         = ppm_op_e'(cmd_code);
   assign do_alloc   = cmd_wr && (op == OP_ALLOC);
   assign do_reset   = cmd_wr && (op == OP_RESET);
   assign do_rx_pop  = cmd_wr && (op == OP_RX_POP);
   assign do_rx_free = cmd_wr && (op == OP_RX_FREE);
   assign do_rel     = cmd_wr && (op == OP_REL);
   assign do_txpush  = cmd_wr && (op == OP_TX_PUSH);
   assign do_txclr   = cmd_wr && (op == OP_TX_CLR);
   assign rx_pop_any = do_rx_pop || do_rx_free;

   assign ev_ack    = ack_wr && !cmd_wr;
   assign ev_tx     = tx_take && !cmd_wr && !ack_wr && !q_empty[QI_TX];
   assign rx_window = rx_req && !cmd_wr && !ack_wr && !tx_take;
   assign rx_accept = rx_window && any_free && !q_full[QI_RX];

   // ---------------- page release source ----------------
   always_comb begin
      rel_en  = 1'b0;
      rel_idx = '0;
      if (do_rx_free && !q_empty[QI_RX]) begin
         rel_en  = 1'b1;
         rel_idx = q_head[QI_RX];
      end else if (do_rel) begin
         rel_en  = 1'b1;
         rel_idx = pkt_num;
      end else if (ev_tx && auto_rel) begin
         rel_en  = 1'b1;
         rel_idx = q_head[QI_TX];
      end
   end

   assign retry_ok = rel_en && pend_q && any_free;
   assign alloc_ok = do_alloc && any_free;
   assign alloc_en = alloc_ok || retry_ok || rx_accept;

   ppm_page_map #(.NUM_PAGES(NUM_PAGES)) i_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_all  (do_reset),
      .rel_en   (rel_en),
      .rel_idx  (rel_idx),
      .alloc_en (alloc_en),
      .grant_idx(grant_idx),
      .any_free (any_free),
      .used_cnt (used_pages)
   );

   // ---------------- allocation result ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= '0;
         pend_q <= 1'b0;
      end else if (do_reset) begin
         res_q  <= '0;
         pend_q <= 1'b0;
      end else if (do_alloc) begin
         res_q  <= any_free ? 8'(grant_idx) : NO_PAGE;
         pend_q <= !any_free;
      end else if (retry_ok) begin
         res_q  <= 8'(grant_idx);
         pend_q <= 1'b0;
      end
   end
   assign alloc_result = res_q;

   // ---------------- queues ----------------
   always_comb begin
      q_clr[QI_TX]    = do_reset || do_txclr;
      q_push[QI_TX]   = do_txpush;
      q_din[QI_TX]    = pkt_num;
      q_pop[QI_TX]    = ev_tx;
      q_clr[QI_DONE]  = do_reset || do_txclr;
      q_push[QI_DONE] = ev_tx && !auto_rel;
      q_din[QI_DONE]  = q_head[QI_TX];
      q_pop[QI_DONE]  = ev_ack && ack_byte[IB_TXDONE];
      q_clr[QI_RX]    = do_reset;
      q_push[QI_RX]   = rx_accept;
      q_din[QI_RX]    = grant_idx;
      q_pop[QI_RX]    = rx_pop_any;
   end

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      ppm_queue #(.DEPTH(NUM_PAGES), .DW(PW)) i_queue (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (q_clr[q]),
         .push   (q_push[q]),
         .din    (q_din[q]),
         .pop    (q_pop[q]),
         .head   (q_head[q]),
         .cnt    (q_cnt[q]),
         .cnt_nxt(q_cnt_nxt[q]),
         .empty  (q_empty[q]),
         .full   (q_full[q])
      );
   end

   assign tx_pending = !q_empty[QI_TX];
   assign tx_head    = q_head[QI_TX];
   assign done_head  = q_empty[QI_DONE] ? NO_PAGE : 8'(q_head[QI_DONE]);
   assign rx_head    = q_empty[QI_RX]   ? NO_PAGE : 8'(q_head[QI_RX]);

   // ---------------- interrupt status ----------------
   always_comb begin
      set_bits   = '0;
      clr_bits   = '0;
      force_bits = '0;
      if (alloc_ok || retry_ok) set_bits[IB_ALLOC] = 1'b1;
      if (do_alloc)             clr_bits[IB_ALLOC] = 1'b1;
      if (rx_accept || (rx_pop_any && (q_cnt[QI_RX] > CW'(1)))) set_bits[IB_RX] = 1'b1;
      if (rx_pop_any && (q_cnt[QI_RX] <= CW'(1)))               clr_bits[IB_RX] = 1'b1;
      if (ev_ack) clr_bits = clr_bits | (ack_byte & ACK_CLR_MASK);
      if (q_cnt_nxt[QI_TX] == '0)   force_bits[IB_TXIDLE] = 1'b1;
      if (q_cnt_nxt[QI_DONE] != '0) force_bits[IB_TXDONE] = 1'b1;
   end

   ppm_irq #(.SW(8)) i_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_bits  (set_bits),
      .clr_bits  (clr_bits),
      .force_bits(force_bits),
      .mask_wr   (mask_wr),
      .mask_din  (mask_byte),
      .status    (int_status),
      .irq       (irq)
   );

   AST_TX_IDLE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      q_empty[QI_TX] |-> int_status[IB_TXIDLE]); // R6
   AST_TXDONE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      !q_empty[QI_DONE] |-> int_status[IB_TXDONE]); // R6
   AST_ALLOC_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      (do_alloc && (used_pages != CW'(NUM_PAGES))) |=> (!alloc_result[7] && int_status[IB_ALLOC])); // R3
   AST_RESET_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      do_reset |=> (!tx_pending && (rx_head == NO_PAGE) && (done_head == NO_PAGE))); // R1
endmodule

// File: tb/test_page_pool_mmu.sv
`timescale 1ns/1ps
module test_page_pool_mmu;
   localparam int N    = 4;
   localparam int PW   = 2;
   localparam int CW   = 3;
   localparam int FULL = (1 << N) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_wr = 1'b0;
   logic [2:0] cmd_code = '0;
   logic [PW-1:0] pkt_num = '0;
   logic auto_rel = 1'b0;
   logic ack_wr = 1'b0;
   logic [7:0] ack_byte = '0;
   logic mask_wr = 1'b0;
   logic [7:0] mask_byte = '0;
   logic tx_take = 1'b0;
   logic rx_req = 1'b0;
   logic rx_accept;
   logic [7:0] alloc_result;
   logic tx_pending;
   logic [PW-1:0] tx_head;
   logic [7:0] done_head;
   logic [7:0] rx_head;
   logic [CW-1:0] used_pages;
   logic [7:0] int_status;
   logic irq;

   always #2.5 clk = ~clk;

   page_pool_mmu #(.NUM_PAGES(N)) i_page_pool_mmu (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code), .pkt_num(pkt_num),
      .auto_rel(auto_rel), .ack_wr(ack_wr), .ack_byte(ack_byte), .mask_wr(mask_wr),
      .mask_byte(mask_byte), .tx_take(tx_take), .rx_req(rx_req), .rx_accept(rx_accept),
      .alloc_result(alloc_result), .tx_pending(tx_pending), .tx_head(tx_head),
      .done_head(done_head), .rx_head(rx_head), .used_pages(used_pages),
      .int_status(int_status), .irq(irq)
   );

   int total = 0;
   int bad = 0;

   // behavioural reference state
   int used = 0, res = 0, pend = 0, st = 4, mk = 0;
   int txq[$];
   int dq[$];
   int rq[$];

   task automatic chk(input string tag, input int act, input int exp, input string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int lowest();
      for (int i = 0; i < N; i++) if (((used >> i) & 1) == 0) return i;
      return -1;
   endfunction

   function automatic int popc(input int v);
      int c = 0;
      for (int i = 0; i < N; i++) c += (v >> i) & 1;
      return c;
   endfunction

   task automatic m_release(input int p);
      used &= ~(1 << p);
      if (pend != 0 && used != FULL) begin
         res = lowest();
         used |= 1 << res;
         st |= 8;
         pend = 0;
      end
   endtask

   task automatic m_rx_pop(input bit rel);
      if (rq.size() == 0) begin
         st &= ~1;
      end else begin
         if (rel) m_release(rq[0]);
         void'(rq.pop_front());
         if (rq.size() != 0) st |= 1; else st &= ~1;
      end
   endtask

   task automatic model(input bit c_wr, input int code, input bit a_wr, input int a_val,
                        input bit m_wr, input int m_val, input bit tk, input bit rr, input int pk,
                        input bit ar);
      int p;
      if (c_wr) begin
         case (code)
            1: begin
               res = 128; st &= ~8;
               if (used != FULL) begin
                  p = lowest(); used |= 1 << p; res = p; st |= 8; pend = 0;
               end else pend = 1;
            end
            2: begin used = 0; txq.delete(); dq.delete(); rq.delete(); res = 0; pend = 0; end
            3: m_rx_pop(0);
            4: m_rx_pop(1);
            5: m_release(pk);
            6: if (txq.size() < N) txq.push_back(pk);
            7: begin txq.delete(); dq.delete(); end
            default: ;
         endcase
      end else if (a_wr) begin
         st &= ~(a_val & 'hD6);
         if (((a_val >> 1) & 1) != 0 && dq.size() != 0) void'(dq.pop_front());
      end else if (tk) begin
         if (txq.size() != 0) begin
            p = txq.pop_front();
            if (ar) m_release(p);
            else if (dq.size() < N) dq.push_back(p);
         end
      end else if (rr) begin
         if (used != FULL && rq.size() < N) begin
            p = lowest(); used |= 1 << p; rq.push_back(p); st |= 1;
         end
      end
      if (m_wr) mk = m_val;
      if (txq.size() == 0) st |= 4;
      if (dq.size() != 0) st |= 2;
      st &= 'hFF;
   endtask

   task automatic compare_all();
      chk("R3", alloc_result, res, "alloc_result");
      chk("R4", done_head, (dq.size() != 0) ? dq[0] : 128, "done_head");
      chk("R4", rx_head, (rq.size() != 0) ? rq[0] : 128, "rx_head");
      chk("R9", tx_pending, (txq.size() != 0) ? 1 : 0, "tx_pending");
      if (txq.size() != 0) chk("R9", tx_head, txq[0], "tx_head");
      chk("R10", used_pages, popc(used), "used_pages");
      chk("R6", int_status, st, "int_status");
      chk("R8", irq, ((st & mk) != 0) ? 1 : 0, "irq");
   endtask

   // one clock: drive after a falling edge, commit at rising edge, compare at next falling edge
   task automatic step(input bit c_wr, input int code, input bit a_wr, input int a_val,
                       input bit m_wr, input int m_val, input bit tk, input bit rr);
      bit exp_acc;
      cmd_wr = c_wr; cmd_code = 3'(code); ack_wr = a_wr; ack_byte = 8'(a_val);
      mask_wr = m_wr; mask_byte = 8'(m_val); tx_take = tk; rx_req = rr;
      exp_acc = rr && !c_wr && !a_wr && !tk && (used != FULL) && (rq.size() < N);
      #1;
      chk("R11", rx_accept, exp_acc ? 1 : 0, "rx_accept");
      @(posedge clk);
      model(c_wr, code, a_wr, a_val, m_wr, m_val, tk, rr, int'(pkt_num), auto_rel);
      @(negedge clk);
      compare_all();
   endtask

   task automatic cmd(input int code);  step(1, code, 0, 0, 0, 0, 0, 0); endtask
   task automatic ack(input int v);     step(0, 0, 1, v, 0, 0, 0, 0);    endtask
   task automatic take();               step(0, 0, 0, 0, 0, 0, 1, 0);    endtask
   task automatic rxr();                step(0, 0, 0, 0, 0, 0, 0, 1);    endtask

   initial begin
      #(200000 * 5);
      bad++;
      $display("FAIL R12 watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: reset state
      compare_all();
      chk("R8", int_status, 4, "reset status");
      chk("R8", irq, 0, "reset irq");
      chk("R4", rx_head, 128, "reset rx_head");

      step(0, 0, 0, 0, 1, 'hFF, 0, 0);
      chk("R8", irq, 1, "irq with idle bit unmasked");

      // R2: lowest free pages in order, then failure
      for (int i = 0; i < N; i++) begin
         cmd(1);
         chk("R2", alloc_result, i, "sequential grant");
      end
      cmd(1);
      chk("R2", alloc_result, 128, "pool exhausted");
      chk("R3", (int_status >> 3) & 1, 0, "alloc bit cleared on failure");

      // R9: send and sent queues
      pkt_num = 2'd1; cmd(6);
      pkt_num = 2'd2; cmd(6);
      auto_rel = 1'b0; take();
      chk("R9", done_head, 1, "sent page queued");
      // R7: acknowledge pops the sent queue
      ack('h02);
      chk("R7", done_head, 128, "sent queue popped by ack");
      // R3: auto-release frees page 2 and the pending allocation takes it
      auto_rel = 1'b1; take();
      chk("R3", alloc_result, 2, "pending retry grant");
      chk("R3", (int_status >> 3) & 1, 1, "alloc bit after retry");

      // R11: receive allocation
      pkt_num = 2'd0; cmd(5);
      rxr();
      chk("R11", rx_head, 0, "rx got page 0");
      rxr();
      pkt_num = 2'd1; cmd(5);
      rxr();
      // R5: pops
      cmd(3);
      chk("R5", rx_head, 1, "rx queue shifted");
      chk("R5", int_status & 1, 1, "rx bit kept while entries remain");
      cmd(4);
      chk("R5", rx_head, 128, "rx queue drained");
      chk("R5", int_status & 1, 0, "rx bit cleared when empty");
      chk("R10", used_pages, 3, "page count after pop-free");
      cmd(3);
      chk("R5", rx_head, 128, "empty pop harmless");

      ack('hFF);
      chk("R7", int_status & 'hD6, 4, "ack clears only selectable bits");
      chk("R7", (int_status >> 3) & 1, 1, "alloc bit not acknowledgeable");

      // R12: command outranks the receive strobe
      step(1, 0, 0, 0, 0, 0, 0, 1);
      chk("R12", rx_head, 128, "rx_req lost to command");
      step(0, 0, 1, 0, 0, 0, 1, 0);
      chk("R12", used_pages, 3, "tx_take lost to ack");

      // R9: full send queue ignores extra enqueue
      pkt_num = 2'd3;
      for (int i = 0; i < N + 1; i++) cmd(6);
      cmd(7);
      chk("R1", tx_pending, 0, "send queue cleared");
      cmd(0);
      cmd(2);
      chk("R1", used_pages, 0, "reset-all empties pool");
      chk("R1", alloc_result, 0, "reset-all result");

      // mixed traffic against the model
      for (int n = 0; n < 3000; n++) begin
         int r = $urandom_range(0, 99);
         pkt_num = 2'($urandom_range(0, N - 1));
         if ($urandom_range(0, 19) == 0) auto_rel = ~auto_rel;
         if (r < 14)      cmd(1);
         else if (r < 16) cmd(2);
         else if (r < 22) cmd(3);
         else if (r < 30) cmd(4);
         else if (r < 38) cmd(5);
         else if (r < 52) cmd(6);
         else if (r < 54) cmd(7);
         else if (r < 62) ack($urandom_range(0, 255));
         else if (r < 72) take();
         else if (r < 86) rxr();
         else if (r < 90) step(0, 0, 0, 0, 1, $urandom_range(0, 255), 0, 0);
         else step($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 1),
                   $urandom_range(0, 255), $urandom_range(0, 1), $urandom_range(0, 255),
                   $urandom_range(0, 1), 1);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule